// File: doc/BRIEF.md
# CEC Transmit Frame Sequencer

This block sits between a host register bus and a bit-level CEC line driver. The host loads one outgoing frame into byte-wide registers: the sending and receiving logical addresses, an opcode and up to `NUM_OPS` operands. The block then passes the frame to the line driver one byte at a time. The driver answers each byte with a one-cycle completion pulse and an acknowledge flag. A negative acknowledge ends the current attempt, and the whole frame is sent again from the header byte until a programmed retry limit is used up. The result is posted in write-1-to-clear status bits.

A frame that carries only a header (a polling message) starts as soon as the destination register is written with its top bit set. A full frame starts from a separate launch register that holds the operand count and a start flag. A flush control clears the opcode, the count and the operand storage one entry per cycle, and aborts any frame in flight. The block also contains a programmable divider that makes the timebase strobe for the line driver. A 48 MHz clock divided by 24 gives the usual 2 MHz.

Top module: `cec_tx_seq`

## Requirements
- R1: A write to the destination register (word 2) with bit 7 set, while idle, sends a single byte equal to {initiator[3:0] (word 1), destination[3:0]}, with `tx_byte_last` high on that byte.
- R2: A write to the launch register (word 4) with bit 4 set sends the header, then the opcode (word 3), then operands 0..N-1 (words 16+k), where N is bits 3:0. `tx_byte_last` is high only on the final byte.
- R3: An operand count above `NUM_OPS` is treated as `NUM_OPS`.
- R4: A nack on any byte ends the attempt, and the next byte offered is the header again. At most L+1 attempts are made, where L is control register (word 0) bits 6:4.
- R5: A successful frame sets bit 5 of status word 5. An exhausted frame sets bit 1 of status word 6, and control bits 6:4 then read the number of retries performed.
- R6: Both status bits clear only when written with 1 at their own position. Writing 0 there leaves them set.
- R7: Launch-register and header-only start writes made while a frame is in progress are ignored. The stored count is kept and no extra frame follows.
- R8: Writing 1 to control bit 7 aborts any frame, drops `tx_byte_valid` and zeroes the opcode, the count and every operand. The bit reads 1 until the clearing completes, then 0. Start writes made during the flush are ignored.
- R9: `cec_tick` pulses once every D cycles, where D is the 6-bit field in bits 5:0 of word 7. D = 0 gives no pulses.
- R10: After reset every register reads 0, no byte is offered and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, one cycle later |
| tx_byte_valid | output | 1 | A frame byte is offered to the line driver |
| tx_byte | output | 8 | Offered byte |
| tx_byte_last | output | 1 | Offered byte ends the frame |
| tx_byte_done | input | 1 | Line driver finished the offered byte (one cycle) |
| tx_byte_ack | input | 1 | Byte was acknowledged (1) or not (0), valid with done |
| cec_tick | output | 1 | Timebase strobe from the divider |

## Verification
The bench aims nacks at the header, at a middle byte and at the final byte. A sequencer that resumed at the failing byte instead of the header, or that counted attempts off by one, would send the wrong number of bytes and would set the wrong status bit. It also drives the zero-retry limit, the maximum limit and an operand count above capacity. A block with these wrong would either stop short or read past the operand store. Start writes made during a frame and during a flush must leave no trace: a design that accepted them would send a second frame or restore stale operands. A design that skipped the clearing would emit old operands after a flush.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  // register word indices
  localparam int REG_CTRL   = 0;
  localparam int REG_SRC    = 1;
  localparam int REG_DST    = 2;
  localparam int REG_OPC    = 3;
  localparam int REG_LAUNCH = 4;
  localparam int REG_STAT0  = 5;
  localparam int REG_STAT1  = 6;
  localparam int REG_CLKDIV = 7;
  localparam int REG_OPBASE = 16;

  // fixed field widths of the register layout
  localparam int LIM_W = 3;   // retry limit, ctrl[6:4]
  localparam int CNT_W = 4;   // operand count, launch[3:0]
  localparam int LA_W  = 4;   // logical address

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND
  } seq_state_t;
endpackage

// File: rtl/cec_tx_tick.sv
module cec_tx_tick #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div_val == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_val - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R9: a zero divisor stops the strobe
  a_r9_stopped: assert property (@(posedge clk) disable iff (rst)
    (div_val == '0) |=> !tick);
endmodule

// File: rtl/cec_tx_fsm.sv
module cec_tx_fsm import cec_tx_pkg::*; #(
  parameter int NUM_OPS = 14,
  localparam int IDX_W  = $clog2(NUM_OPS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_hdr,
  input  logic             start_full,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic [LIM_W-1:0] retry_lim,
  input  logic             flushing,
  input  logic             byte_done,
  input  logic             byte_ack,
  output logic             fetch,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             byte_valid,
  output logic             byte_last,
  output logic             done_ok,
  output logic             done_fail,
  output logic [LIM_W-1:0] fail_tries,
  output logic             busy
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx, last_idx;
  logic [LIM_W-1:0] tries, lim_q;

  assign fetch     = (state == ST_FETCH);
  assign fetch_idx = idx;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      last_idx   <= '0;
      tries      <= '0;
      lim_q      <= '0;
      byte_valid <= 1'b0;
      byte_last  <= 1'b0;
      done_ok    <= 1'b0;
      done_fail  <= 1'b0;
      fail_tries <= '0;
    end else begin
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
      if (flushing) begin
        state      <= ST_IDLE;
        byte_valid <= 1'b0;
        byte_last  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_hdr || start_full) begin
              idx      <= '0;
              tries    <= '0;
              lim_q    <= retry_lim;
              last_idx <= start_hdr ? '0 : IDX_W'(frame_cnt) + IDX_W'(1);
              state    <= ST_FETCH;
            end
          end
          ST_FETCH: begin
            byte_valid <= 1'b1;
            byte_last  <= (idx == last_idx);
            state      <= ST_SEND;
          end
          default: begin
            if (byte_done) begin
              byte_valid <= 1'b0;
              byte_last  <= 1'b0;
              if (byte_ack) begin
                if (idx == last_idx) begin
                  done_ok <= 1'b1;
                  state   <= ST_IDLE;
                end else begin
                  idx   <= idx + IDX_W'(1);
                  state <= ST_FETCH;
                end
              end else if (tries == lim_q) begin
                done_fail  <= 1'b1;
                fail_tries <= tries;
                state      <= ST_IDLE;
              end else begin
                tries <= tries + LIM_W'(1);
                idx   <= '0;
                state <= ST_FETCH;
              end
            end
          end
        endcase
      end
    end
  end

  // R4: attempts never exceed the latched limit
  a_r4_tries_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (tries <= lim_q));
  // R5: a frame ends in exactly one outcome
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(done_ok && done_fail));
  // R2: an offered byte stays offered until the driver answers
  a_r2_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_done && !flushing) |=> byte_valid);
  // R8: a flush withdraws the byte
  a_r8_flush_abort: assert property (@(posedge clk) disable iff (rst)
    flushing |=> !byte_valid);
endmodule

// File: rtl/cec_tx_regs.sv
module cec_tx_regs import cec_tx_pkg::*; #(
  parameter int NUM_OPS = 14,
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 6,
  localparam int IDX_W  = $clog2(NUM_OPS + 2),
  localparam int OP_AW  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              seq_busy,
  input  logic              fetch,
  input  logic [IDX_W-1:0]  fetch_idx,
  input  logic              done_ok,
  input  logic              done_fail,
  input  logic [LIM_W-1:0]  fail_tries,
  output logic              start_hdr,
  output logic              start_full,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic [LIM_W-1:0]  retry_lim,
  output logic              flushing,
  output logic [DIV_W-1:0]  div_val,
  output logic [7:0]        byte_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(REG_SRC);
  localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(REG_DST);
  localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(REG_OPC);
  localparam logic [ADDR_W-1:0] A_LNCH = ADDR_W'(REG_LAUNCH);
  localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(REG_STAT0);
  localparam logic [ADDR_W-1:0] A_ST1  = ADDR_W'(REG_STAT1);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_CLKDIV);
  localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(REG_OPBASE);
  localparam logic [ADDR_W-1:0] A_OPE  = ADDR_W'(REG_OPBASE + NUM_OPS);

  logic [LA_W-1:0]  src_q, dst_q;
  logic [7:0]       opc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ok_q, fail_q;
  logic [OP_AW-1:0] flush_ptr;
  logic [7:0]       opmem [NUM_OPS];
  logic [7:0]       hdr_l, opc_l, opr_l;
  logic [1:0]       sel_q;

  logic wr_ctrl, wr_src, wr_dst, wr_opc, wr_lnch, wr_st0, wr_st1, wr_div, wr_op;
  logic [OP_AW-1:0] op_wr_idx, op_rd_idx;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_src  = reg_wr && (reg_addr == A_SRC);
  assign wr_dst  = reg_wr && (reg_addr == A_DST);
  assign wr_opc  = reg_wr && (reg_addr == A_OPC);
  assign wr_lnch = reg_wr && (reg_addr == A_LNCH);
  assign wr_st0  = reg_wr && (reg_addr == A_ST0);
  assign wr_st1  = reg_wr && (reg_addr == A_ST1);
  assign wr_div  = reg_wr && (reg_addr == A_DIV);
  assign wr_op   = reg_wr && (reg_addr >= A_OPB) && (reg_addr < A_OPE);

  assign op_wr_idx = OP_AW'(reg_addr - A_OPB);
  assign op_rd_idx = (fetch_idx >= IDX_W'(2)) ? OP_AW'(fetch_idx - IDX_W'(2)) : '0;

  assign frame_cnt = (cnt_q > CNT_W'(NUM_OPS)) ? CNT_W'(NUM_OPS) : cnt_q;
  assign byte_q    = (sel_q == 2'd0) ? hdr_l : (sel_q == 2'd1) ? opc_l : opr_l;

  // operand store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (flushing)
      opmem[flush_ptr] <= '0;
    else if (wr_op)
      opmem[op_wr_idx] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (fetch)
      opr_l <= opmem[op_rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q      <= '0;
      dst_q      <= '0;
      opc_q      <= '0;
      cnt_q      <= '0;
      ok_q       <= 1'b0;
      fail_q     <= 1'b0;
      retry_lim  <= '0;
      flushing   <= 1'b0;
      flush_ptr  <= '0;
      div_val    <= '0;
      start_hdr  <= 1'b0;
      start_full <= 1'b0;
      hdr_l      <= '0;
      opc_l      <= '0;
      sel_q      <= '0;
      reg_rdata  <= '0;
    end else begin
      start_hdr  <= wr_dst && reg_wdata[7] && !seq_busy && !flushing;
      start_full <= wr_lnch && reg_wdata[4] && !seq_busy && !flushing;

      if (wr_src) src_q <= reg_wdata[LA_W-1:0];
      if (wr_dst) dst_q <= reg_wdata[LA_W-1:0];
      if (wr_opc && !flushing) opc_q <= reg_wdata;
      if (wr_lnch && !seq_busy && !flushing) cnt_q <= reg_wdata[CNT_W-1:0];
      if (wr_div) div_val <= reg_wdata[DIV_W-1:0];

      if (flushing) begin
        if (flush_ptr == OP_AW'(NUM_OPS - 1))
          flushing <= 1'b0;
        else
          flush_ptr <= flush_ptr + OP_AW'(1);
      end

      if (done_fail) retry_lim <= fail_tries;
      if (wr_ctrl) begin
        retry_lim <= reg_wdata[6:4];
        if (reg_wdata[7] && !flushing) begin
          flushing  <= 1'b1;
          flush_ptr <= '0;
          opc_q     <= '0;
          cnt_q     <= '0;
        end
      end

      if (done_ok) ok_q <= 1'b1;
      else if (wr_st0 && reg_wdata[5]) ok_q <= 1'b0;
      if (done_fail) fail_q <= 1'b1;
      else if (wr_st1 && reg_wdata[1]) fail_q <= 1'b0;

      if (fetch) begin
        hdr_l <= {src_q, dst_q};
        opc_l <= opc_q;
        sel_q <= (fetch_idx == '0) ? 2'd0 : (fetch_idx == IDX_W'(1)) ? 2'd1 : 2'd2;
      end

      if (reg_addr == A_CTRL)      reg_rdata <= {flushing, retry_lim, 4'b0};
      else if (reg_addr == A_SRC)  reg_rdata <= {4'b0, src_q};
      else if (reg_addr == A_DST)  reg_rdata <= {4'b0, dst_q};
      else if (reg_addr == A_OPC)  reg_rdata <= opc_q;
      else if (reg_addr == A_LNCH) reg_rdata <= {{(8 - CNT_W){1'b0}}, cnt_q};
      else if (reg_addr == A_ST0)  reg_rdata <= {2'b0, ok_q, 5'b0};
      else if (reg_addr == A_ST1)  reg_rdata <= {6'b0, fail_q, 1'b0};
      else if (reg_addr == A_DIV)  reg_rdata <= {{(8 - DIV_W){1'b0}}, div_val};
      else                         reg_rdata <= '0;
    end
  end

  // R6: the success bit rises only after a completed frame
  a_r6_ok_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> $past(done_ok));
  // R7: a launch write during a frame leaves the count alone
  a_r7_cnt_held: assert property (@(posedge clk) disable iff (rst)
    (wr_lnch && seq_busy) |=> $stable(cnt_q));
  // R8: a flush request is taken at once
  a_r8_flush_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && reg_wdata[7]) |=> flushing);
endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq import cec_tx_pkg::*; #(
  parameter int NUM_OPS = 14,
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 6,
  localparam int IDX_W  = $clog2(NUM_OPS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_byte_last,
  input  logic              tx_byte_done,
  input  logic              tx_byte_ack,
  output logic              cec_tick
);
  logic             start_hdr, start_full, flushing, fetch, busy;
  logic             done_ok, done_fail;
  logic [CNT_W-1:0] frame_cnt;
  logic [LIM_W-1:0] retry_lim, fail_tries;
  logic [DIV_W-1:0] div_val;
  logic [IDX_W-1:0] fetch_idx;

  cec_tx_regs #(.NUM_OPS(NUM_OPS), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_busy(busy), .fetch(fetch), .fetch_idx(fetch_idx),
    .done_ok(done_ok), .done_fail(done_fail), .fail_tries(fail_tries),
    .start_hdr(start_hdr), .start_full(start_full), .frame_cnt(frame_cnt),
    .retry_lim(retry_lim), .flushing(flushing), .div_val(div_val), .byte_q(tx_byte)
  );

  cec_tx_fsm #(.NUM_OPS(NUM_OPS)) u_fsm (
    .clk(clk), .rst(rst),
    .start_hdr(start_hdr), .start_full(start_full), .frame_cnt(frame_cnt),
    .retry_lim(retry_lim), .flushing(flushing),
    .byte_done(tx_byte_done), .byte_ack(tx_byte_ack),
    .fetch(fetch), .fetch_idx(fetch_idx),
    .byte_valid(tx_byte_valid), .byte_last(tx_byte_last),
    .done_ok(done_ok), .done_fail(done_fail), .fail_tries(fail_tries), .busy(busy)
  );

  cec_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(cec_tick)
  );
endmodule

// File: tb/tb_cec_tx_seq.sv
module tb_cec_tx_seq;
  localparam int NUM_OPS = 14;
  localparam int ADDR_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_byte_valid, tx_byte_last, cec_tick;
  logic [7:0] tx_byte;
  logic tx_byte_done = 1'b0;
  logic tx_byte_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  logic [7:0] blog [64];
  logic       llog [64];

  always #2.5 clk = ~clk;

  cec_tx_seq #(.NUM_OPS(NUM_OPS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_byte_last(tx_byte_last),
    .tx_byte_done(tx_byte_done), .tx_byte_ack(tx_byte_ack), .cec_tick(cec_tick)
  );

  // cnt[15:12] lim[11:9] nack_pos[8:4] nack_times[3:0]
  localparam logic [15:0] VEC [6] = '{
    {4'd3,  3'd2, 5'd31, 4'd0},
    {4'd0,  3'd0, 5'd0,  4'd1},
    {4'd2,  3'd3, 5'd3,  4'd2},
    {4'd5,  3'd1, 5'd1,  4'd5},
    {4'd1,  3'd7, 5'd0,  4'd7},
    {4'd14, 3'd0, 5'd31, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // line driver model: answers each byte after two cycles, nacks byte npos of an
  // attempt for the first ntimes attempts; returns once the line stays quiet
  task automatic serve(input int npos, input int ntimes, output int nbytes);
    int idle = 0, pos = 0, nacks = 0;
    bit nk;
    nbytes = 0;
    while (idle < 24) begin
      @(negedge clk);
      if (tx_byte_valid) begin
        idle = 0;
        if (nbytes < 64) begin blog[nbytes] = tx_byte; llog[nbytes] = tx_byte_last; end
        nbytes++;
        repeat (2) @(negedge clk);
        nk = (pos == npos) && (nacks < ntimes);
        tx_byte_ack = !nk; tx_byte_done = 1'b1;
        @(negedge clk);
        tx_byte_done = 1'b0; tx_byte_ack = 1'b0;
        if (nk) begin nacks++; pos = 0; end else pos++;
      end else idle++;
    end
  endtask

  function automatic logic [7:0] opv(input int e, input int k);
    return 8'(k * 29 + e * 7 + 3);
  endfunction

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, ticks;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 8'h00, "R10 reset reg", d, 0);
    end
    ticks = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); ticks += cec_tick; end
    chk(ticks == 0 && !tx_byte_valid, "R10 idle after reset", ticks, 0);

    // table walk: R2 R4 R5 R6
    for (int e = 0; e < 6; e++) begin
      int cnt, lim, npos, nt, len, tot, natt;
      bit ok, good;
      logic [7:0] hdr;
      cnt = int'(VEC[e][15:12]); lim = int'(VEC[e][11:9]);
      npos = int'(VEC[e][8:4]);  nt = int'(VEC[e][3:0]);
      len = 2 + cnt;
      ok = (nt <= lim);
      natt = ok ? nt : lim + 1;
      tot = natt * (npos + 1) + (ok ? len : 0);
      hdr = {4'(e + 1), 4'(14 - e)};
      wr(1, e + 1); wr(2, 14 - e); wr(3, 8'h40 + e);
      for (int k = 0; k < cnt; k++) wr(16 + k, opv(e, k));
      wr(0, lim << 4);
      wr(4, 8'h10 | cnt);
      serve(npos, nt, n);
      chk(n == tot, $sformatf("R4 byte count vec%0d", e), n, tot);
      good = 1'b1;
      for (int a = 0; a < natt; a++) if (blog[a * (npos + 1)] != hdr) good = 1'b0;
      chk(good, $sformatf("R4 restart from header vec%0d", e), good, 1);
      if (ok && n == tot) begin
        good = 1'b1;
        for (int k = 0; k < len; k++) begin
          logic [7:0] x;
          x = (k == 0) ? hdr : (k == 1) ? 8'(8'h40 + e) : opv(e, k - 2);
          if (blog[tot - len + k] != x || llog[tot - len + k] != (k == len - 1)) good = 1'b0;
        end
        chk(good, $sformatf("R2 frame content vec%0d", e), good, 1);
      end
      rd(5, d); chk(d[5] == ok, $sformatf("R5 ok bit vec%0d", e), d, ok);
      rd(6, d); chk(d[1] == !ok, $sformatf("R5 fail bit vec%0d", e), d, !ok);
      if (!ok) begin
        rd(0, d); chk(int'(d[6:4]) == lim, $sformatf("R5 retries used vec%0d", e), d[6:4], lim);
      end
      wr(5, 8'h20); wr(6, 8'h02);
      rd(5, d); chk(d == 0, "R6 ok cleared", d, 0);
      rd(6, d); chk(d == 0, "R6 fail cleared", d, 0);
    end

    // R3 clamp: operands 0..13 of vec5 are still stored
    wr(0, 8'h00); wr(4, 8'h1F);
    serve(31, 0, n);
    chk(n == NUM_OPS + 2, "R3 clamped length", n, NUM_OPS + 2);
    chk(blog[NUM_OPS + 1] == opv(5, NUM_OPS - 1) && llog[NUM_OPS + 1], "R3 final byte", blog[NUM_OPS + 1], opv(5, NUM_OPS - 1));

    // R6 writing zero keeps the bit
    wr(5, 8'hDF); rd(5, d); chk(d[5], "R6 zero write keeps ok", d, 8'h20);
    wr(5, 8'h20); rd(5, d); chk(d == 0, "R6 one clears ok", d, 0);

    // R1 header-only poll
    wr(1, 5); wr(2, 8'h8F);
    serve(31, 0, n);
    chk(n == 1 && blog[0] == 8'h5F && llog[0], "R1 poll byte", blog[0], 8'h5F);
    rd(5, d); chk(d[5], "R1 poll done", d, 8'h20);
    wr(5, 8'h20);

    // R7 start writes during a frame
    wr(1, 2); wr(2, 3); wr(3, 8'h77); wr(16, 8'hA1); wr(17, 8'hA2);
    wr(4, 8'h12);
    repeat (2) @(negedge clk);
    wr(4, 8'h15); wr(2, 8'h83);
    rd(4, d); chk(d == 8'h02, "R7 count kept", d, 2);
    serve(31, 0, n);
    chk(n == 4 && blog[0] == 8'h23 && blog[3] == 8'hA2, "R7 single frame", n, 4);
    wr(5, 8'h20);

    // R8 flush
    wr(4, 8'h12);
    repeat (3) @(negedge clk);
    wr(0, 8'h80);
    rd(0, d); chk(d[7], "R8 flush bit set", d, 8'h80);
    chk(!tx_byte_valid, "R8 byte withdrawn", tx_byte_valid, 0);
    wr(4, 8'h11);
    serve(31, 0, n);
    chk(n == 0, "R8 start ignored in flush", n, 0);
    rd(0, d); chk(d == 8'h00, "R8 flush bit self clears", d, 0);
    rd(5, d); chk(d == 8'h00, "R8 aborted frame no ok", d, 0);
    wr(4, 8'h12);
    serve(31, 0, n);
    chk(n == 4 && blog[1] == 0 && blog[2] == 0 && blog[3] == 0, "R8 store zeroed", blog[2], 0);
    wr(5, 8'h20);

    // R9 divider
    wr(7, 3); repeat (4) @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); ticks += cec_tick; end
    chk(ticks == 10, "R9 divide by 3", ticks, 10);
    wr(7, 1); repeat (2) @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); ticks += cec_tick; end
    chk(ticks == 20, "R9 divide by 1", ticks, 20);
    wr(7, 0); repeat (2) @(negedge clk);
    ticks = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); ticks += cec_tick; end
    chk(ticks == 0, "R9 stopped", ticks, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule